// File: doc/BRIEF.md
# DMA Address Port Write Interceptor

This block sits on a byte-wide I/O write path in front of a legacy four-channel DMA controller. It watches writes to the channel address ports and page ports. For each channel it keeps a shadow copy of the 16-bit virtual address and the 4-bit page that software has written. Address-port bytes are absorbed into the shadow. A single shared flag chooses the low or high byte, and a write to the controller's flip-flop clear port resets that flag. A page-port write is held back. The block hands the 20-bit virtual address to an external translation unit and waits for the 24-bit real address. It then replays three writes on the downstream port: real low byte, real high byte and real page.

The block accepts no new input while a translation and its replay are in progress. Writes to ports it does not handle are forwarded unchanged. Word-wide writes and writes to the unassigned page-port holes raise error pulses and are dropped. An out-of-range page value is fatal. A write to either of the two reboot ports sends a reset command byte and then stops the block.

Top module: `dmaPortRemap`

## Requirements
- R1: After reset, inReady is 1 and outValid, xlReqValid, errWord, errPort, fatalPage and halted are 0. The shadow addresses and pages are zero, and the shared byte flag selects the low byte.
- R2: A byte write to port 0x00, 0x02, 0x04 or 0x06 is absorbed and not forwarded. These ports belong to channels 0, 1, 2 and 3. The byte goes to that channel's shadow low byte when the shared flag is clear and to its high byte when the flag is set. The flag flips on every such write, whichever channel the write is for.
- R3: A byte write to port 0x0C clears the shared flag. The write is also forwarded downstream with its port and data unchanged.
- R4: A byte write with value below 0x10 to port 0x87, 0x83, 0x81 or 0x82 (the page ports of channels 0, 1, 2 and 3) is not forwarded. It stores the page and issues one translation request. The request address is {page[3:0], shadow high byte, shadow low byte}.
- R5: After the translation response, exactly three downstream writes follow, in this order: port 2×channel with real[7:0], port 2×channel with real[15:8], then the channel's page port with real[23:16].
- R6: inReady stays 0 from the acceptance of a valid page write until the third replay write has completed. While xlReqValid waits for xlReqReady, xlReqAddr holds stable.
- R7: A page-port byte write with value 0x10 or greater sets fatalPage. fatalPage stays set until reset. No translation request and no downstream write follow, and inReady stays 0. A value of 0x0F is valid.
- R8: A write with inWide = 1 to any port produces a one-cycle errWord pulse and is dropped: nothing is forwarded and no request is made.
- R9: A byte write to port 0x84, 0x85 or 0x86 produces a one-cycle errPort pulse and is dropped.
- R10: A byte write to port 0x680 or 0x80 produces one downstream write of 0xFE to port 0x64. After that write, halted is set until reset and inReady stays 0.
- R11: A byte write to any other port is forwarded once with its port and data unchanged. outValid, outPort and outData hold while outReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Incoming I/O write present |
| inReady | output | 1 | Block can accept an incoming write |
| inPort | input | 16 | Incoming I/O port address |
| inData | input | 8 | Incoming write byte |
| inWide | input | 1 | Incoming write is word-wide |
| outValid | output | 1 | Downstream write present |
| outReady | input | 1 | Downstream accepts the write |
| outPort | output | 16 | Downstream port address |
| outData | output | 8 | Downstream write byte |
| xlReqValid | output | 1 | Translation request present |
| xlReqReady | input | 1 | Translator accepts the request |
| xlReqAddr | output | 20 | Virtual address to translate |
| xlRspValid | input | 1 | Translation result present |
| xlRspReady | output | 1 | Block accepts the result |
| xlRspAddr | input | 24 | Real address result |
| errWord | output | 1 | One-cycle pulse: word-wide write dropped |
| errPort | output | 1 | One-cycle pulse: unassigned page port written |
| fatalPage | output | 1 | Sticky: out-of-range page value seen |
| halted | output | 1 | Sticky: reboot command sent |

## Verification
Several properties are checked on every cycle. Output and request payloads hold while stalled. Input stays blocked during translation, after a fatal page and after a reboot. The two error pulses never coincide. A word-wide write causes no follow-up traffic. A clear-port write is forwarded with its own port and data. Some behaviour can only be shown by the bench's scenarios, which compare the translator's observed request and the recorded downstream writes against expected values: the shared byte flag steering bytes across channels, its clearing, the composed virtual address, the order and content of the three replayed writes, and the reboot command.

// File: rtl/dmaRemapPkg.sv
package dmaRemapPkg;
  localparam int PortW   = 16;
  localparam int DataW   = 8;
  localparam int ChanW   = 2;
  localparam int NumChan = 1 << ChanW;
  localparam int PageW   = 4;
  localparam int VirtW   = 2 * DataW + PageW;
  localparam int RealW   = 3 * DataW;

  localparam logic [PortW-1:0] PortClear     = 16'h000C;
  localparam logic [PortW-1:0] PortReboot    = 16'h0680;
  localparam logic [PortW-1:0] PortRebootAlt = 16'h0080;
  localparam logic [PortW-1:0] PortResetCmd  = 16'h0064;
  localparam logic [DataW-1:0] ResetCmdByte  = 8'hFE;

  typedef enum logic [2:0] {
    PcForward, PcAddr, PcClear, PcPage, PcBadPage, PcReboot
  } portClassT;

  typedef enum logic [2:0] {
    SelFwd, SelRealLo, SelRealHi, SelRealPg, SelReboot
  } outSelT;

  typedef struct packed {
    logic   latchIn;
    logic   wrAddr;
    logic   clrTog;
    logic   wrPage;
    logic   latchReal;
    outSelT outSel;
  } strobeT;

  function automatic portClassT classify(input logic [PortW-1:0] p);
    if (p[PortW-1:3] == '0 && !p[0]) return PcAddr;
    if (p == PortClear) return PcClear;
    if (p == 16'h0081 || p == 16'h0082 || p == 16'h0083 || p == 16'h0087) return PcPage;
    if (p >= 16'h0084 && p <= 16'h0086) return PcBadPage;
    if (p == PortReboot || p == PortRebootAlt) return PcReboot;
    return PcForward;
  endfunction

  function automatic logic [ChanW-1:0] chanOf(input logic [PortW-1:0] p);
    if (!p[7]) return p[ChanW:1];
    case (p[2:0])
      3'd7:    return 2'd0;
      3'd3:    return 2'd1;
      3'd1:    return 2'd2;
      default: return 2'd3;
    endcase
  endfunction

  function automatic logic [PortW-1:0] pagePortOf(input logic [ChanW-1:0] ch);
    case (ch)
      2'd0:    return 16'h0087;
      2'd1:    return 16'h0083;
      2'd2:    return 16'h0081;
      default: return 16'h0082;
    endcase
  endfunction

  function automatic logic [PortW-1:0] addrPortOf(input logic [ChanW-1:0] ch);
    return {{(PortW-ChanW-1){1'b0}}, ch, 1'b0};
  endfunction
endpackage

// File: rtl/dmaRemapPath.sv
module dmaRemapPath
  import dmaRemapPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [PortW-1:0] inPort,
  input  logic [DataW-1:0] inData,
  input  logic [RealW-1:0] xlRspAddr,
  output logic [VirtW-1:0] xlReqAddr,
  output logic [PortW-1:0] outPort,
  output logic [DataW-1:0] outData
);
  logic [ChanW-1:0] inChan, chanQ;
  logic [PortW-1:0] fwdPort;
  logic [DataW-1:0] fwdData;
  logic [RealW-1:0] realQ;
  logic             togQ;
  logic [NumChan-1:0][DataW-1:0] chLo, chHi;
  logic [NumChan-1:0][PageW-1:0] chPg;

  assign inChan = chanOf(inPort);

  for (genvar g = 0; g < NumChan; g++) begin : gShadow
    logic [DataW-1:0] loR, hiR;
    logic [PageW-1:0] pgR;
    always_ff @(posedge clk) begin
      if (!rstN) begin
        loR <= '0;
        hiR <= '0;
        pgR <= '0;
      end else begin
        if (stb.wrAddr && inChan == ChanW'(g) && !togQ) loR <= inData;
        if (stb.wrAddr && inChan == ChanW'(g) && togQ)  hiR <= inData;
        if (stb.wrPage && inChan == ChanW'(g))          pgR <= inData[PageW-1:0];
      end
    end
    assign chLo[g] = loR;
    assign chHi[g] = hiR;
    assign chPg[g] = pgR;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      togQ    <= 1'b0;
      chanQ   <= '0;
      fwdPort <= '0;
      fwdData <= '0;
      realQ   <= '0;
    end else begin
      if (stb.clrTog)      togQ <= 1'b0;
      else if (stb.wrAddr) togQ <= ~togQ;
      if (stb.latchIn) begin
        chanQ   <= inChan;
        fwdPort <= inPort;
        fwdData <= inData;
      end
      if (stb.latchReal) realQ <= xlRspAddr;
    end
  end

  assign xlReqAddr = {chPg[chanQ], chHi[chanQ], chLo[chanQ]};

  always_comb begin
    case (stb.outSel)
      SelRealLo: begin outPort = addrPortOf(chanQ); outData = realQ[DataW-1:0];         end
      SelRealHi: begin outPort = addrPortOf(chanQ); outData = realQ[2*DataW-1:DataW];   end
      SelRealPg: begin outPort = pagePortOf(chanQ); outData = realQ[RealW-1:2*DataW];   end
      SelReboot: begin outPort = PortResetCmd;      outData = ResetCmdByte;             end
      default:   begin outPort = fwdPort;           outData = fwdData;                  end
    endcase
  end
endmodule

// File: rtl/dmaRemapCtrl.sv
module dmaRemapCtrl
  import dmaRemapPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic [PortW-1:0] inPort,
  input  logic [DataW-1:0] inData,
  input  logic             inWide,
  input  logic             outReady,
  input  logic             xlReqReady,
  input  logic             xlRspValid,
  output logic             inReady,
  output logic             outValid,
  output logic             xlReqValid,
  output logic             xlRspReady,
  output logic             errWord,
  output logic             errPort,
  output logic             fatalPage,
  output logic             halted,
  output strobeT           stb
);
  typedef enum logic [3:0] {
    StIdle, StFwd, StReq, StRsp, StEmitLo, StEmitHi, StEmitPg, StReboot, StStop
  } stateT;

  stateT     st, stNxt;
  portClassT cls;
  logic      accept, badPage;
  logic      setWord, setPort, setFatal, setHalt;

  assign cls     = classify(inPort);
  assign badPage = |inData[DataW-1:PageW];
  assign accept  = inValid && (st == StIdle);

  always_comb begin
    stNxt    = st;
    stb      = '0;
    setWord  = 1'b0;
    setPort  = 1'b0;
    setFatal = 1'b0;
    setHalt  = 1'b0;
    case (st)
      StIdle: if (accept) begin
        if (inWide) setWord = 1'b1;
        else begin
          case (cls)
            PcAddr:    stb.wrAddr = 1'b1;
            PcClear:   begin stb.latchIn = 1'b1; stb.clrTog = 1'b1; stNxt = StFwd; end
            PcBadPage: setPort = 1'b1;
            PcReboot:  stNxt = StReboot;
            PcPage: begin
              if (badPage) begin setFatal = 1'b1; stNxt = StStop; end
              else begin stb.wrPage = 1'b1; stb.latchIn = 1'b1; stNxt = StReq; end
            end
            default:   begin stb.latchIn = 1'b1; stNxt = StFwd; end
          endcase
        end
      end
      StFwd:    if (outReady) stNxt = StIdle;
      StReq:    if (xlReqReady) stNxt = StRsp;
      StRsp:    if (xlRspValid) begin stb.latchReal = 1'b1; stNxt = StEmitLo; end
      StEmitLo: begin stb.outSel = SelRealLo; if (outReady) stNxt = StEmitHi; end
      StEmitHi: begin stb.outSel = SelRealHi; if (outReady) stNxt = StEmitPg; end
      StEmitPg: begin stb.outSel = SelRealPg; if (outReady) stNxt = StIdle; end
      StReboot: begin stb.outSel = SelReboot; if (outReady) begin setHalt = 1'b1; stNxt = StStop; end end
      default:  stNxt = StStop;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      st        <= StIdle;
      errWord   <= 1'b0;
      errPort   <= 1'b0;
      fatalPage <= 1'b0;
      halted    <= 1'b0;
    end else begin
      st        <= stNxt;
      errWord   <= setWord;
      errPort   <= setPort;
      fatalPage <= fatalPage | setFatal;
      halted    <= halted | setHalt;
    end
  end

  assign inReady    = (st == StIdle);
  assign outValid   = (st == StFwd) || (st == StEmitLo) || (st == StEmitHi) ||
                      (st == StEmitPg) || (st == StReboot);
  assign xlReqValid = (st == StReq);
  assign xlRspReady = (st == StRsp);
endmodule

// File: rtl/dmaPortRemap.sv
module dmaPortRemap
  import dmaRemapPkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  output logic             inReady,
  input  logic [PortW-1:0] inPort,
  input  logic [DataW-1:0] inData,
  input  logic             inWide,
  output logic             outValid,
  input  logic             outReady,
  output logic [PortW-1:0] outPort,
  output logic [DataW-1:0] outData,
  output logic             xlReqValid,
  input  logic             xlReqReady,
  output logic [VirtW-1:0] xlReqAddr,
  input  logic             xlRspValid,
  output logic             xlRspReady,
  input  logic [RealW-1:0] xlRspAddr,
  output logic             errWord,
  output logic             errPort,
  output logic             fatalPage,
  output logic             halted
);
  strobeT stb;

  dmaRemapCtrl i_ctrl (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inPort(inPort), .inData(inData),
    .inWide(inWide), .outReady(outReady), .xlReqReady(xlReqReady),
    .xlRspValid(xlRspValid), .inReady(inReady), .outValid(outValid),
    .xlReqValid(xlReqValid), .xlRspReady(xlRspReady), .errWord(errWord),
    .errPort(errPort), .fatalPage(fatalPage), .halted(halted), .stb(stb)
  );

  dmaRemapPath i_path (
    .clk(clk), .rstN(rstN), .stb(stb), .inPort(inPort), .inData(inData),
    .xlRspAddr(xlRspAddr), .xlReqAddr(xlReqAddr), .outPort(outPort), .outData(outData)
  );
endmodule

// File: rtl/dmaPortRemapChk.sv
module dmaPortRemapChk
  import dmaRemapPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             inValid,
  input logic             inReady,
  input logic [PortW-1:0] inPort,
  input logic [DataW-1:0] inData,
  input logic             inWide,
  input logic             outValid,
  input logic             outReady,
  input logic [PortW-1:0] outPort,
  input logic [DataW-1:0] outData,
  input logic             xlReqValid,
  input logic             xlReqReady,
  input logic [VirtW-1:0] xlReqAddr,
  input logic             xlRspReady,
  input logic             errWord,
  input logic             errPort,
  input logic             fatalPage,
  input logic             halted
);
  assert_out_hold_R11: assert property (@(posedge clk) disable iff (!rstN)
    outValid && !outReady |=> outValid && $stable(outPort) && $stable(outData));

  assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rstN)
    xlReqValid && !xlReqReady |=> xlReqValid && $stable(xlReqAddr));

  assert_stall_R6: assert property (@(posedge clk) disable iff (!rstN)
    (xlReqValid || xlRspReady) |-> !inReady);

  assert_fatal_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    fatalPage |=> fatalPage && !inReady && !outValid && !xlReqValid);

  assert_halt_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    halted |=> halted && !inReady && !outValid);

  assert_err_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({errWord, errPort}));

  assert_wide_drop_R8: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && inWide |=> !outValid && !xlReqValid && errWord);

  assert_clear_fwd_R3: assert property (@(posedge clk) disable iff (!rstN)
    inValid && inReady && !inWide && inPort == PortClear |=>
      outValid && outPort == $past(inPort) && outData == $past(inData));
endmodule

bind dmaPortRemap dmaPortRemapChk i_chk (.*);

// File: tb/test_dmaPortRemap.sv
`timescale 1ns/1ps
module test_dmaPortRemap;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inWide = 1'b0;
  logic [15:0] inPort = '0;
  logic [7:0]  inData = '0;
  logic        outReady = 1'b1;
  logic        xlReqReady = 1'b0, xlRspValid = 1'b0;
  logic [23:0] xlRspAddr = '0;
  logic        inReady, outValid, xlReqValid, xlRspReady;
  logic [15:0] outPort;
  logic [7:0]  outData;
  logic [19:0] xlReqAddr;
  logic        errWord, errPort, fatalPage, halted;

  int checks = 0, fails = 0;
  int obsCount = 0, reqCount = 0, wordCount = 0, portCount = 0;
  logic [15:0] obsPort [64];
  logic [7:0]  obsData [64];
  logic [19:0] lastVirt = '0;
  bit finished = 0;

  always #5 clk = ~clk;

  dmaPortRemap i_dmaPortRemap (.*);

  function automatic logic [23:0] model(input logic [19:0] v);
    return {4'h0, v} + 24'h1A2B3C;
  endfunction

  always @(negedge clk) begin
    if (rstN && outValid && outReady && obsCount < 64) begin
      obsPort[obsCount] = outPort;
      obsData[obsCount] = outData;
      obsCount++;
    end
    if (rstN && errWord) wordCount++;
    if (rstN && errPort) portCount++;
  end

  initial begin
    forever begin
      @(negedge clk);
      if (xlReqValid) begin
        lastVirt = xlReqAddr;
        reqCount++;
        xlReqReady = 1'b1;
        @(negedge clk);
        xlReqReady = 1'b0;
        repeat (2) @(negedge clk);
        while (!xlRspReady) @(negedge clk);
        xlRspAddr  = model(lastVirt);
        xlRspValid = 1'b1;
        @(negedge clk);
        xlRspValid = 1'b0;
      end
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic clearObs();
    obsCount = 0; reqCount = 0; wordCount = 0; portCount = 0;
  endtask

  task automatic doReset();
    @(posedge clk); #1;
    rstN = 1'b0; inValid = 1'b0; outReady = 1'b1;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    @(negedge clk);
    clearObs();
  endtask

  task automatic sendWrite(input logic [15:0] p, input logic [7:0] d, input logic w);
    @(posedge clk); #1;
    inValid = 1'b1; inPort = p; inData = d; inWide = w;
    @(negedge clk);
    while (!inReady) @(negedge clk);
    @(posedge clk); #1;
    inValid = 1'b0; inWide = 1'b0;
  endtask

  task automatic waitIdle();
    @(negedge clk);
    while (!inReady) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic pageReplay(input string req, input logic [15:0] pPort, input logic [15:0] aPort,
                            input logic [7:0] pg, input logic [19:0] expVirt);
    logic [23:0] r;
    clearObs();
    sendWrite(pPort, pg, 1'b0);
    @(negedge clk);
    check({req, " R6 stall"}, inReady, 0);
    waitIdle();
    r = model(expVirt);
    check({req, " R4 requests"}, reqCount, 1);
    check({req, " R4 virt"}, lastVirt, expVirt);
    check({req, " R5 count"}, obsCount, 3);
    check({req, " R5 lo"}, {obsPort[0], obsData[0]}, {aPort, r[7:0]});
    check({req, " R5 hi"}, {obsPort[1], obsData[1]}, {aPort, r[15:8]});
    check({req, " R5 pg"}, {obsPort[2], obsData[2]}, {pPort, r[23:16]});
  endtask

  task automatic testReset();
    check("R1 inReady", inReady, 1);
    check("R1 quiet", {outValid, xlReqValid, errWord, errPort, fatalPage, halted}, 0);
  endtask

  task automatic testForward();
    clearObs();
    sendWrite(16'h03F8, 8'h5A, 1'b0);
    waitIdle();
    check("R11 count", obsCount, 1);
    check("R11 write", {obsPort[0], obsData[0]}, {16'h03F8, 8'h5A});
    clearObs();
    outReady = 1'b0;
    sendWrite(16'h0071, 8'h33, 1'b0);
    repeat (3) @(negedge clk);
    check("R11 hold", {outValid, outPort, outData}, {1'b1, 16'h0071, 8'h33});
    @(posedge clk); #1 outReady = 1'b1;
    waitIdle();
    check("R11 once", obsCount, 1);
  endtask

  task automatic testCaptureReplay();
    clearObs();
    sendWrite(16'h0002, 8'h34, 1'b0);
    sendWrite(16'h0002, 8'h12, 1'b0);
    waitIdle();
    check("R2 absorbed", obsCount, 0);
    pageReplay("ch1", 16'h0083, 16'h0002, 8'h07, 20'h71234);
  endtask

  task automatic testSharedToggle();
    sendWrite(16'h0000, 8'hAA, 1'b0);
    sendWrite(16'h0006, 8'hBB, 1'b0);
    waitIdle();
    pageReplay("R2 ch0", 16'h0087, 16'h0000, 8'h01, 20'h100AA);
    pageReplay("R2 ch3", 16'h0082, 16'h0006, 8'h02, 20'h2BB00);
  endtask

  task automatic testClear();
    sendWrite(16'h0004, 8'h11, 1'b0);
    clearObs();
    sendWrite(16'h000C, 8'h9C, 1'b0);
    waitIdle();
    check("R3 forwarded", obsCount, 1);
    check("R3 write", {obsPort[0], obsData[0]}, {16'h000C, 8'h9C});
    sendWrite(16'h0004, 8'h22, 1'b0);
    sendWrite(16'h0004, 8'h33, 1'b0);
    waitIdle();
    pageReplay("R3 R7 ch2 page0F", 16'h0081, 16'h0004, 8'h0F, 20'hF3322);
  endtask

  task automatic testBadPort();
    clearObs();
    sendWrite(16'h0085, 8'h05, 1'b0);
    waitIdle();
    check("R9 errPort", portCount, 1);
    check("R9 dropped", {obsCount[7:0], reqCount[7:0]}, 0);
  endtask

  task automatic testWide();
    clearObs();
    sendWrite(16'h0087, 8'h03, 1'b1);
    waitIdle();
    sendWrite(16'h03F8, 8'h44, 1'b1);
    waitIdle();
    check("R8 errWord", wordCount, 2);
    check("R8 dropped", {obsCount[7:0], reqCount[7:0]}, 0);
  endtask

  task automatic testFatal();
    clearObs();
    sendWrite(16'h0087, 8'h10, 1'b0);
    repeat (10) @(negedge clk);
    check("R7 fatal", fatalPage, 1);
    check("R7 stalled", inReady, 0);
    check("R7 silent", {obsCount[7:0], reqCount[7:0]}, 0);
  endtask

  task automatic testReboot(input logic [15:0] p);
    clearObs();
    sendWrite(p, 8'h00, 1'b0);
    repeat (10) @(negedge clk);
    check("R10 count", obsCount, 1);
    check("R10 cmd", {obsPort[0], obsData[0]}, {16'h0064, 8'hFE});
    check("R10 halted", {halted, inReady}, 2'b10);
  endtask

  task automatic testLowFirst();
    sendWrite(16'h0000, 8'h55, 1'b0);
    waitIdle();
    pageReplay("R1 lowfirst", 16'h0087, 16'h0000, 8'h00, 20'h00055);
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finish();
  end

  initial begin
    doReset();
    testReset();
    testForward();
    testCaptureReplay();
    testSharedToggle();
    testClear();
    testBadPort();
    testWide();
    testFatal();
    doReset();
    testReboot(16'h0680);
    doReset();
    testReboot(16'h0080);
    doReset();
    testReset();
    testLowFirst();
    finish();
  end
endmodule